// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

This block sits between a transmit byte stream and the media side of an Ethernet controller. Frame bytes arrive one per cycle on a valid/ready/last stream. On their way through, the block can overwrite the source-address field with the device MAC address and can append a CRC-32 frame check sequence. It then steers the finished frame to the transmit port, to a loopback port, or drops it, as a 2-bit loopback mode selects.

Data bytes pass straight through from input to output with no added latency. The appended CRC bytes follow the last data byte, and the input is held off while they go out. The configuration (source-insert disable, global CRC disable, CRC-16 select, loopback mode) and the per-command CRC disable are sampled with the first byte of each frame and hold until the frame ends. The MAC address is expected to stay static.

A frame that would exceed 1540 bytes on the output, CRC included, is truncated. The rest of its input is consumed silently, and an error pulse reports the truncation. Selecting CRC-16 is not supported: such a frame is consumed without output and raises its own error pulse.

Top module: `tx_frame_asm`

## Requirements
- R1: When cfg_no_sa_ins is 0, frame bytes 6 to 11 (counting from 0) are replaced by mac_addr, with mac_addr[47:40] at byte 6 and mac_addr[7:0] at byte 11. When it is 1, all bytes pass unchanged. Frames shorter than 12 bytes have only their existing bytes in that range replaced.
- R2: Four CRC bytes are appended only when cfg_no_crc is 0, cmd_no_crc is 0, cfg_loop_mode is 0 and cfg_crc16 is 0. Otherwise the output is exactly the data bytes, with the last flag on the last data byte.
- R3: The CRC is the reflected CRC-32 (polynomial 0x04C11DB7), with an all-ones start and a complemented result. It is taken over the bytes as sent, including any substituted address. The 32-bit result goes out most significant byte first, so the ASCII bytes "123456789" are followed by 0xCB 0xF4 0x39 0x26. The last flag marks the final CRC byte.
- R4: Loop mode 0 sends the frame to the tx port. Loop mode 1 sends it to the lb port, never with a CRC. Only one port ever carries the frame.
- R5: Loop modes 2 and 3 consume every input byte (in_ready high) and raise valid on neither output.
- R6: With cfg_crc16 at 1, the frame is consumed with no output, and err_crc_sel is high for exactly one cycle: the cycle after the frame's last input byte is accepted.
- R7: The output frame never exceeds 1540 bytes. The data part is limited to 1536 bytes when a CRC is appended and to 1540 bytes otherwise. A frame that exactly meets its limit passes whole, without an error.
- R8: When a frame is longer than its limit, the output carries the first limit bytes (plus the CRC when enabled) with last on the final output byte. The remaining input bytes are consumed with no output. err_oversize is high for one cycle, the cycle after the frame's in_last byte is accepted.
- R9: in_ready follows the ready of the selected output port, and is held low while CRC bytes go out. Under any ready pattern no byte is lost, duplicated or reordered.
- R10: After reset, tx_valid, lb_valid, err_crc_sel and err_oversize are low, and the block waits for the first byte of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Input byte is the last of the frame |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| mac_addr | input | 48 | Device MAC address, first wire byte in bits 47:40 |
| cfg_no_sa_ins | input | 1 | 1 disables source-address substitution |
| cfg_no_crc | input | 1 | 1 disables CRC append globally |
| cfg_crc16 | input | 1 | CRC-16 select (unsupported, flags an error) |
| cfg_loop_mode | input | 2 | 0 transmit, 1 loopback port, 2 and 3 drop |
| cmd_no_crc | input | 1 | Per-frame CRC disable from the transmit command |
| tx_valid | output | 1 | Transmit port byte valid |
| tx_data | output | 8 | Transmit port byte |
| tx_last | output | 1 | Transmit port last byte of frame |
| tx_ready | input | 1 | Transmit port sink ready |
| lb_valid | output | 1 | Loopback port byte valid |
| lb_data | output | 8 | Loopback port byte |
| lb_last | output | 1 | Loopback port last byte of frame |
| lb_ready | input | 1 | Loopback port sink ready |
| err_crc_sel | output | 1 | One-cycle pulse: frame ended with CRC-16 selected |
| err_oversize | output | 1 | One-cycle pulse: frame was truncated |

## Verification
The properties watch every cycle for the cycle-level rules. A CRC byte held under backpressure stays put. The drain and drop phases emit nothing while input is taken. Error strobes last only one cycle. The CRC phase is entered only for a frame that both asked for a CRC and is routed to the tx port. The byte counter never passes the length limit. Whether the bytes are correct can only be shown by the bench's frame scenarios, which compare each frame against a model. That covers the substituted address, the CRC value and its byte order, the exact truncation point, the route taken for each loop mode, and byte integrity under irregular ready patterns.

// File: rtl/tfa_pkg.sv
package tfa_pkg;

  typedef enum logic [1:0] {
    ST_DATA  = 2'd0,
    ST_CRC   = 2'd1,
    ST_DRAIN = 2'd2
  } tfa_state_e;

  // One byte step of a reflected CRC register, least significant bit first.
  function automatic logic [31:0] crc_step(input logic [31:0] cur,
                                           input logic [7:0]  din,
                                           input logic [31:0] poly_refl);
    logic [31:0] c;
    c = cur ^ {24'h0, din};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ poly_refl) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/tfa_crc32.sv
module tfa_crc32 #(
  parameter logic [31:0] POLY_REFL = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        start,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);
  import tfa_pkg::*;

  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (en) crc_d = crc_step(start ? 32'hFFFF_FFFF : crc_q, din, POLY_REFL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= 32'hFFFF_FFFF;
    else if (en) crc_q <= crc_d;
  end

  assign fcs = ~crc_q;
endmodule

// File: rtl/tfa_route.sv
module tfa_route #(
  parameter int W      = 8,
  parameter int NPORTS = 2,
  localparam int SEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                       s_valid,
  input  logic [W-1:0]               s_data,
  input  logic                       s_last,
  input  logic [SEL_W-1:0]           s_sel,
  input  logic                       s_drop,
  output logic                       s_ready,
  output logic [NPORTS-1:0]          m_valid,
  output logic [NPORTS-1:0][W-1:0]   m_data,
  output logic [NPORTS-1:0]          m_last,
  input  logic [NPORTS-1:0]          m_ready
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign m_valid[p] = s_valid && !s_drop && (s_sel == SEL_W'(p));
    assign m_data[p]  = s_data;
    assign m_last[p]  = s_last;
  end

  assign s_ready = s_drop ? 1'b1 : m_ready[s_sel];
endmodule

// File: rtl/tx_frame_asm.sv
module tx_frame_asm #(
  parameter int MAX_BYTES = 1540,
  parameter int CRC_BYTES = 4,
  parameter int MAC_BYTES = 6,
  parameter int SA_FIRST  = 6,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int CIDX_W   = $clog2(CRC_BYTES),
  localparam int MAC_W    = MAC_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  input  logic [MAC_W-1:0] mac_addr,
  input  logic             cfg_no_sa_ins,
  input  logic             cfg_no_crc,
  input  logic             cfg_crc16,
  input  logic [1:0]       cfg_loop_mode,
  input  logic             cmd_no_crc,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             tx_ready,
  output logic             lb_valid,
  output logic [7:0]       lb_data,
  output logic             lb_last,
  input  logic             lb_ready,
  output logic             err_crc_sel,
  output logic             err_oversize
);
  import tfa_pkg::*;

  localparam logic [CNT_W-1:0] LIM_CRC_M1 = CNT_W'(MAX_BYTES - CRC_BYTES - 1);
  localparam logic [CNT_W-1:0] LIM_RAW_M1 = CNT_W'(MAX_BYTES - 1);
  localparam logic [CIDX_W-1:0] CIDX_LAST = CIDX_W'(CRC_BYTES - 1);

  // ---------------- state registers ----------------
  tfa_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CIDX_W-1:0] cidx_q, cidx_d;
  logic              trunc_q, trunc_d;
  logic [1:0]        lat_mode_q;
  logic              lat_nosa_q, lat_crc_en_q, lat_drop_q, lat_crc16_q;
  logic              err_ovr_q, err_ovr_d, err_sel_q, err_sel_d;

  // ---------------- effective per-frame configuration ----------------
  logic       first;
  logic       live_crc_en, live_drop;
  logic [1:0] e_mode;
  logic       e_nosa, e_crc_en, e_drop, e_crc16;

  assign first       = (state_q == ST_DATA) && (cnt_q == '0);
  assign live_drop   = cfg_loop_mode[1] | cfg_crc16;
  assign live_crc_en = !cfg_no_crc && !cmd_no_crc && (cfg_loop_mode == 2'd0) && !cfg_crc16;

  assign e_mode   = first ? cfg_loop_mode : lat_mode_q;
  assign e_nosa   = first ? cfg_no_sa_ins : lat_nosa_q;
  assign e_crc_en = first ? live_crc_en   : lat_crc_en_q;
  assign e_drop   = first ? live_drop     : lat_drop_q;
  assign e_crc16  = first ? cfg_crc16     : lat_crc16_q;

  logic at_limit;
  assign at_limit = (cnt_q == (e_crc_en ? LIM_CRC_M1 : LIM_RAW_M1));

  // ---------------- source address substitution ----------------
  logic [7:0] data_byte;
  always_comb begin
    data_byte = in_data;
    for (int k = 0; k < MAC_BYTES; k++) begin
      if (!e_nosa && (cnt_q == CNT_W'(SA_FIRST + k)))
        data_byte = mac_addr[(MAC_BYTES - 1 - k) * 8 +: 8];
    end
  end

  // ---------------- CRC ----------------
  logic        in_hs, crc_en;
  logic [31:0] fcs;
  logic [7:0]  fcs_byte;

  tfa_crc32 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (crc_en),
    .start (first),
    .din   (data_byte),
    .fcs   (fcs)
  );

  assign fcs_byte = fcs[(CRC_BYTES - 1 - int'(cidx_q)) * 8 +: 8];

  // ---------------- output stream and router ----------------
  logic       s_valid, s_last, s_drop, s_ready;
  logic [7:0] s_data;
  logic [1:0] s_mode;
  logic [1:0]       m_valid, m_last;
  logic [1:0][7:0]  m_data;

  always_comb begin
    s_valid  = 1'b0;
    s_data   = data_byte;
    s_last   = 1'b0;
    s_mode   = e_mode;
    s_drop   = e_drop;
    in_ready = 1'b0;
    unique case (state_q)
      ST_DATA: begin
        s_valid  = in_valid;
        s_last   = (in_last || at_limit) && !e_crc_en;
        in_ready = s_ready;
      end
      ST_CRC: begin
        s_valid = 1'b1;
        s_data  = fcs_byte;
        s_last  = (cidx_q == CIDX_LAST);
        s_mode  = lat_mode_q;
        s_drop  = 1'b0;
      end
      default: begin
        s_drop   = 1'b1;
        in_ready = 1'b1;
      end
    endcase
  end

  tfa_route #(.W(8), .NPORTS(2)) u_route (
    .s_valid (s_valid),
    .s_data  (s_data),
    .s_last  (s_last),
    .s_sel   (s_mode[0]),
    .s_drop  (s_drop),
    .s_ready (s_ready),
    .m_valid (m_valid),
    .m_data  (m_data),
    .m_last  (m_last),
    .m_ready ({lb_ready, tx_ready})
  );

  assign tx_valid = m_valid[0];
  assign tx_data  = m_data[0];
  assign tx_last  = m_last[0];
  assign lb_valid = m_valid[1];
  assign lb_data  = m_data[1];
  assign lb_last  = m_last[1];

  assign in_hs  = in_valid && in_ready;
  assign crc_en = in_hs && (state_q == ST_DATA);

  // ---------------- next state ----------------
  logic latch_en;
  assign latch_en = in_hs && first;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cidx_d    = cidx_q;
    trunc_d   = trunc_q;
    err_ovr_d = 1'b0;
    err_sel_d = 1'b0;
    unique case (state_q)
      ST_DATA: begin
        if (in_hs) begin
          if (in_last || at_limit) begin
            cnt_d   = '0;
            trunc_d = !in_last;
            if (e_crc_en) begin
              state_d = ST_CRC;
              cidx_d  = '0;
            end else if (!in_last) begin
              state_d = ST_DRAIN;
            end else begin
              err_sel_d = e_crc16;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_CRC: begin
        if (s_ready) begin
          cidx_d = cidx_q + 1'b1;
          if (cidx_q == CIDX_LAST) state_d = trunc_q ? ST_DRAIN : ST_DATA;
        end
      end
      default: begin
        if (in_hs && in_last) begin
          state_d   = ST_DATA;
          err_ovr_d = 1'b1;
          err_sel_d = lat_crc16_q;
        end
      end
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_DATA;
      cnt_q     <= '0;
      cidx_q    <= '0;
      trunc_q   <= 1'b0;
      err_ovr_q <= 1'b0;
      err_sel_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      cidx_q    <= cidx_d;
      trunc_q   <= trunc_d;
      err_ovr_q <= err_ovr_d;
      err_sel_q <= err_sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_mode_q   <= 2'd0;
      lat_nosa_q   <= 1'b0;
      lat_crc_en_q <= 1'b0;
      lat_drop_q   <= 1'b0;
      lat_crc16_q  <= 1'b0;
    end else if (latch_en) begin
      lat_mode_q   <= cfg_loop_mode;
      lat_nosa_q   <= cfg_no_sa_ins;
      lat_crc_en_q <= live_crc_en;
      lat_drop_q   <= live_drop;
      lat_crc16_q  <= cfg_crc16;
    end
  end

  assign err_crc_sel  = err_sel_q;
  assign err_oversize = err_ovr_q;

  // ---------------- assertions ----------------
  // R3, R9: a CRC byte stalled by the sink is held unchanged
  p_crc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CRC && tx_valid && !tx_ready) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R2, R4: CRC phase only for a CRC-enabled frame routed to the tx port
  p_crc_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CRC) |-> (lat_crc_en_q && lat_mode_q == 2'd0 && !lb_valid));

  // R8: while draining, input is taken and nothing is emitted
  p_drain_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |-> (in_ready && !tx_valid && !lb_valid));

  // R8: oversize strobe lasts one cycle
  p_ovr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_oversize |=> !err_oversize);

  // R6: CRC-16 strobe lasts one cycle
  p_sel_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_crc_sel |=> !err_crc_sel);

  // R5, R6: a dropped frame in progress emits nothing
  p_drop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && cnt_q != '0 && lat_drop_q) |-> (!tx_valid && !lb_valid));

  // R7: byte counter stays within the limit
  p_cnt_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_RAW_M1);
endmodule

// File: tb/tb_tx_frame_asm.sv
`timescale 1ns/1ps
module tb_tx_frame_asm;

  localparam int MAXB   = 1540;
  localparam int WD_CYC = 150000;

  typedef struct packed {
    logic [1:0]  mode;
    logic        nosa;
    logic        nocrc;
    logic        cmdnc;
    logic        crc16;
    logic [10:0] len;
    logic [7:0]  seed;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd64,   8'h11},
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd20,   8'h22},
    '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd30,   8'h33},
    '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 11'd30,   8'h44},
    '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd40,   8'h55},
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 11'd25,   8'h66},
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 11'd25,   8'h77},
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 11'd25,   8'h88},
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd1536, 8'h99},
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd1540, 8'hAA},
    '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd1541, 8'hBB},
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd1,    8'hC1}
  };

  function automatic string vtag(input int i);
    case (i)
      0, 1:  return "R1";
      2, 3:  return "R2";
      4:     return "R4";
      5, 6:  return "R5";
      7:     return "R6";
      8:     return "R7";
      9, 10: return "R8";
      default: return "R9";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_last, in_ready;
  logic [7:0]  in_data;
  logic [47:0] mac_addr;
  logic        cfg_no_sa_ins, cfg_no_crc, cfg_crc16, cmd_no_crc;
  logic [1:0]  cfg_loop_mode;
  logic        tx_valid, tx_last, tx_ready, lb_valid, lb_last, lb_ready;
  logic [7:0]  tx_data, lb_data;
  logic        err_crc_sel, err_oversize;

  always #2.5 clk = ~clk;

  tx_frame_asm dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .mac_addr(mac_addr), .cfg_no_sa_ins(cfg_no_sa_ins), .cfg_no_crc(cfg_no_crc),
    .cfg_crc16(cfg_crc16), .cfg_loop_mode(cfg_loop_mode), .cmd_no_crc(cmd_no_crc),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .lb_valid(lb_valid), .lb_data(lb_data), .lb_last(lb_last), .lb_ready(lb_ready),
    .err_crc_sel(err_crc_sel), .err_oversize(err_oversize)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] in_buf  [0:2047];
  logic [7:0] exp_buf [0:2047];
  logic [7:0] got_tx  [0:2047];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ exp_buf[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  // Sends in_buf[0:len-1] with the given setup; compares both ports against the model.
  task automatic run_frame(input logic [1:0] mode, input logic nosa, input logic nocrc,
                           input logic cmdnc, input logic crc16, input int len,
                           input logic [7:0] seed, input string tag);
    bit crc_en, drop, trunc;
    int lim, nd, en, etx, elb;
    int idx = 0, ntx = 0, nlb = 0, txl = -1, lbl = -1, bad_b = 0, post = 0;
    int nsel = 0, novr = 0;
    logic [31:0] f;
    crc_en = !nocrc && !cmdnc && mode == 2'd0 && !crc16;
    drop   = mode[1] || crc16;
    lim    = crc_en ? MAXB - 4 : MAXB;
    nd     = (len > lim) ? lim : len;
    trunc  = len > lim;
    for (int i = 0; i < nd; i++)
      exp_buf[i] = (!nosa && i >= 6 && i < 12) ? mac_addr[(11 - i) * 8 +: 8] : in_buf[i];
    en = nd;
    if (crc_en) begin
      f = ref_fcs(nd);
      for (int j = 0; j < 4; j++) exp_buf[nd + j] = f[(3 - j) * 8 +: 8];
      en = nd + 4;
    end
    etx = (!drop && mode == 2'd0) ? en : 0;
    elb = (!drop && mode == 2'd1) ? en : 0;
    @(negedge clk);
    cfg_loop_mode = mode; cfg_no_sa_ins = nosa; cfg_no_crc = nocrc;
    cmd_no_crc = cmdnc; cfg_crc16 = crc16;
    while (cyc < WD_CYC && post < 4) begin
      in_valid = (idx < len);
      in_data  = in_buf[idx < len ? idx : 0];
      in_last  = (idx == len - 1);
      tx_ready = ((cyc + int'(seed)) % 4) != 3;
      lb_ready = ((cyc + int'(seed)) % 5) != 2;
      #1;
      if (err_crc_sel)  nsel++;
      if (err_oversize) novr++;
      if (tx_valid && tx_ready) begin
        if (ntx < 2048) got_tx[ntx] = tx_data;
        if (ntx >= en || tx_data !== exp_buf[ntx]) bad_b++;
        if (tx_last) txl = ntx;
        ntx++;
      end
      if (lb_valid && lb_ready) begin
        if (nlb >= en || lb_data !== exp_buf[nlb]) bad_b++;
        if (lb_last) lbl = nlb;
        nlb++;
      end
      if (in_valid && in_ready) idx++;
      if (idx >= len && ntx >= etx && nlb >= elb) post++;
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    check(ntx == etx, tag, "tx byte count", ntx, etx);
    check(nlb == elb, tag, "lb byte count", nlb, elb);
    check(bad_b == 0, tag, "mismatched bytes", bad_b, 0);
    if (etx > 0) check(txl == etx - 1, tag, "tx last position", txl, etx - 1);
    if (elb > 0) check(lbl == elb - 1, tag, "lb last position", lbl, elb - 1);
    check(nsel == (crc16 ? 1 : 0), tag, "err_crc_sel pulses", nsel, crc16 ? 1 : 0);
    check(novr == (trunc ? 1 : 0), tag, "err_oversize pulses", novr, trunc ? 1 : 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
    mac_addr = 48'h02_1A_2B_3C_4D_5E;
    cfg_no_sa_ins = 1'b0; cfg_no_crc = 1'b0; cfg_crc16 = 1'b0;
    cfg_loop_mode = 2'd0; cmd_no_crc = 1'b0; tx_ready = 1'b0; lb_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R10: reset state
    check(!tx_valid && !lb_valid, "R10", "valid during reset", {tx_valid, lb_valid}, 0);
    check(!err_crc_sel && !err_oversize, "R10", "errors during reset",
          {err_crc_sel, err_oversize}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check(!tx_valid && !lb_valid && !err_crc_sel && !err_oversize, "R10",
          "idle after reset", {tx_valid, lb_valid, err_crc_sel, err_oversize}, 0);

    // Table of frame vectors
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < int'(VECS[v].len); i++)
        in_buf[i] = 8'(int'(VECS[v].seed) + i * 7) ^ 8'(i >> 3);
      run_frame(VECS[v].mode, VECS[v].nosa, VECS[v].nocrc, VECS[v].cmdnc,
                VECS[v].crc16, int'(VECS[v].len), VECS[v].seed, vtag(v));
    end

    // R3: known CRC value on ASCII "123456789", no substitution
    for (int i = 0; i < 9; i++) in_buf[i] = 8'h31 + 8'(i);
    run_frame(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 9, 8'h03, "R3");
    check({got_tx[9], got_tx[10], got_tx[11], got_tx[12]} == 32'hCBF43926, "R3",
          "known check value", {got_tx[9], got_tx[10], got_tx[11], got_tx[12]}, 32'hCBF43926);

    // R9, R4: back-to-back loopback and transmit frames under backpressure
    for (int i = 0; i < 13; i++) in_buf[i] = 8'hE0 ^ 8'(i);
    run_frame(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 13, 8'h02, "R9");
    run_frame(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 13, 8'h01, "R9");

    if (cyc >= WD_CYC) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_CYC);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule